// File: doc/BRIEF.md
# PRBS Self-Test Generator and Checker

This block is a built-in self-test engine for a serial, one-bit-per-cycle datapath. It has two independent paths. The transmit path runs a linear feedback shift register and sends a pseudo-random bit on every active cycle. The receive path watches the incoming stream and predicts each bit from the bits it has already seen. It counts every bit that differs from its prediction. An input selects either a short sequence (degree 9, period 511) or a long one (degree 15, period 32767). A control write starts or stops both paths. That write also clears the verdict and the error count.

The checker needs no alignment with the generator. After each start it fills its register from the first N valid bits it receives, where N is the degree of the selected sequence. From then on it free-runs on its own predicted bits, so a single corrupted bit costs exactly one error. The pass flag comes up only after a run of 128 matching bits. Any miscompare forces the flag low, and it stays low until the next control write. The error counter is 8 bits wide and saturates. With continuous mode off, the generator stops after one full period. With continuous mode on, it keeps transmitting.

Top module: `prbs_bist`

## Requirements
- R1: After reset, `pass_o` is 0, `err_cnt_o` is 0 and `tx_valid_o` is 0.
- R2: With `seq_sel_i`=0 at the start write, the transmit bits o[k] start with nine 1s. After that, each bit follows o[k+9] = o[k] XOR o[k+4], which is the polynomial x^9+x^5+1.
- R3: With `seq_sel_i`=1 at the start write, the transmit bits start with fifteen 1s. After that, each bit follows o[k+15] = o[k] XOR o[k+1], which is the polynomial x^15+x^14+1.
- R4: With `cont_mode_i`=0, `tx_valid_o` is high for exactly one period after a start write. That is 511 cycles for the short sequence and 32767 cycles for the long one. The first valid bit appears in the cycle after the write edge.
- R5: With `cont_mode_i`=1, `tx_valid_o` stays high and the bit stream repeats with the sequence period.
- R6: After a start write, the checker loads its register from the first N valid received bits (N = 9 or 15), whatever the phase of the stream. It compares no bits during that loading.
- R7: `pass_o` goes to 1 in the cycle after the 128th consecutive matching compared bit, provided no miscompare has occurred since the last control write.
- R8: A miscompare raises `err_cnt_o` by exactly one, one cycle later. It forces `pass_o` to 0 until the next control write. Later bits are predicted independently of the received value.
- R9: `err_cnt_o` saturates at 255.
- R10: A control write (`ctrl_we_i`=1) clears `pass_o` and `err_cnt_o`. If the write is a stop (`ctrl_start_i`=0), `tx_valid_o` goes low in the next cycle and received bits are no longer compared.
- R11: A received bit with `rx_valid_i`=0 is neither loaded nor compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_start_i | input | 1 | Written value: 1 start, 0 stop |
| seq_sel_i | input | 1 | Sequence select, sampled on the write: 0 short, 1 long |
| cont_mode_i | input | 1 | Continuous transmission enable |
| tx_data_o | output | 1 | Generated bit |
| tx_valid_o | output | 1 | Generator active |
| rx_data_i | input | 1 | Received bit |
| rx_valid_i | input | 1 | Received bit qualifier |
| pass_o | output | 1 | Verdict: 1 pass, 0 fail |
| err_cnt_o | output | 8 | Saturating miscompare count |

## Verification
After the edge that samples a start write, the cycles are numbered from 0. Transmit bit i is due in cycle i, so each bench cycle compares the output at the falling edge against a sequence it builds from the recurrence. A received bit is judged at the edge that ends its cycle. For that reason the error count and the pass flag are read one cycle after the bit that should change them. The pass flag is checked both in the cycle just before and in the cycle just after bit N+128. Stop writes and clears are checked at the first falling edge after the write edge.

// File: rtl/prbs_bist_pkg.sv
package prbs_bist_pkg;
  localparam int unsigned LFSR_W  = 15;
  localparam int unsigned PER_W   = 15;
  localparam int unsigned SHORT_N = 9;
  localparam int unsigned LONG_N  = 15;

  typedef logic [LFSR_W-1:0] lfsr_t;

  function automatic logic lfsr_fb(lfsr_t s, logic long_sel);
    return long_sel ? (s[LONG_N-1] ^ s[LONG_N-2]) : (s[SHORT_N-1] ^ s[SHORT_N-5]);
  endfunction

  function automatic logic lfsr_head(lfsr_t s, logic long_sel);
    return long_sel ? s[LONG_N-1] : s[SHORT_N-1];
  endfunction

  function automatic logic [PER_W-1:0] seq_period(logic long_sel);
    return long_sel ? PER_W'((1 << LONG_N) - 1) : PER_W'((1 << SHORT_N) - 1);
  endfunction

  function automatic logic [3:0] seq_len(logic long_sel);
    return long_sel ? 4'(LONG_N) : 4'(SHORT_N);
  endfunction
endpackage

// File: rtl/prbs_gen.sv
module prbs_gen
  import prbs_bist_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic start_i,
  input  logic sel_i,
  input  logic cont_i,
  output logic data_o,
  output logic valid_o
);
  logic             active_q, long_q;
  lfsr_t            st_q;
  logic [PER_W-1:0] cnt_q;
  logic             last;

  assign last = (cnt_q == seq_period(long_q) - PER_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      long_q   <= 1'b0;
      st_q     <= '0;
      cnt_q    <= '0;
    end else if (we_i) begin
      active_q <= start_i;
      long_q   <= sel_i;
      st_q     <= '1;
      cnt_q    <= '0;
    end else if (active_q) begin
      st_q  <= {st_q[LFSR_W-2:0], lfsr_fb(st_q, long_q)};
      cnt_q <= last ? '0 : cnt_q + PER_W'(1);
      if (last && !cont_i) active_q <= 1'b0;
    end
  end

  assign data_o  = active_q & lfsr_head(st_q, long_q);
  assign valid_o = active_q;

  AST_ONE_SHOT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && last && !cont_i && !we_i) |=> !valid_o); // R4
  AST_STOP_IDLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !start_i) |=> !valid_o); // R10
  AST_SEED_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && start_i) |=> (valid_o && data_o)); // R2
endmodule

// File: rtl/prbs_chk.sv
module prbs_chk
  import prbs_bist_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic start_i,
  input  logic sel_i,
  input  logic rx_data_i,
  input  logic rx_valid_i,
  output logic cmp_vld_o,
  output logic mism_o
);
  logic       armed_q, long_q, in_sync, exp_bit;
  logic [3:0] fill_q;
  lfsr_t      chk_q;

  assign in_sync   = (fill_q == seq_len(long_q));
  assign exp_bit   = lfsr_fb(chk_q, long_q);
  assign cmp_vld_o = armed_q & in_sync & rx_valid_i;
  assign mism_o    = cmp_vld_o & (rx_data_i != exp_bit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      long_q  <= 1'b0;
      fill_q  <= '0;
      chk_q   <= '0;
    end else if (we_i) begin
      armed_q <= start_i;
      long_q  <= sel_i;
      fill_q  <= '0;
      chk_q   <= '0;
    end else if (armed_q && rx_valid_i) begin
      if (!in_sync) begin
        chk_q  <= {chk_q[LFSR_W-2:0], rx_data_i};
        fill_q <= fill_q + 4'd1;
      end else begin
        // free-run on prediction so one bad bit gives one error
        chk_q <= {chk_q[LFSR_W-2:0], exp_bit};
      end
    end
  end

  AST_NO_CMP_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> !cmp_vld_o); // R6
  AST_IDLE_NO_CMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_i |-> !cmp_vld_o); // R11
endmodule

// File: rtl/prbs_stat.sv
module prbs_stat #(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned PASS_RUN = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             cmp_vld_i,
  input  logic             mism_i,
  output logic             pass_o,
  output logic [CNT_W-1:0] err_cnt_o
);
  localparam int unsigned RUN_W = $clog2(PASS_RUN + 1);

  logic [RUN_W-1:0] run_q;
  logic [CNT_W-1:0] cnt_q;
  logic             fail_q, pass_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      cnt_q  <= '0;
      fail_q <= 1'b0;
      pass_q <= 1'b0;
    end else if (clr_i) begin
      run_q  <= '0;
      cnt_q  <= '0;
      fail_q <= 1'b0;
      pass_q <= 1'b0;
    end else if (cmp_vld_i) begin
      if (mism_i) begin
        fail_q <= 1'b1;
        pass_q <= 1'b0;
        run_q  <= '0;
        if (cnt_q != '1) cnt_q <= cnt_q + CNT_W'(1);
      end else if (run_q != RUN_W'(PASS_RUN)) begin
        run_q <= run_q + RUN_W'(1);
        if (run_q == RUN_W'(PASS_RUN - 1) && !fail_q) pass_q <= 1'b1;
      end
    end
  end

  assign pass_o    = pass_q;
  assign err_cnt_o = cnt_q;

  AST_CNT_SATURATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '1 && !clr_i) |=> (cnt_q == '1)); // R9
  AST_FAIL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_q && !clr_i) |=> !pass_q); // R8
  AST_PASS_AFTER_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pass_q) |-> $past(cmp_vld_i && !mism_i)); // R7
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_W'(1))); // R8
endmodule

// File: rtl/prbs_bist.sv
module prbs_bist #(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned PASS_RUN = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic             ctrl_start_i,
  input  logic             seq_sel_i,
  input  logic             cont_mode_i,
  output logic             tx_data_o,
  output logic             tx_valid_o,
  input  logic             rx_data_i,
  input  logic             rx_valid_i,
  output logic             pass_o,
  output logic [CNT_W-1:0] err_cnt_o
);
  logic cmp_vld, mism;

  prbs_gen u_gen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctrl_we_i),
    .start_i (ctrl_start_i),
    .sel_i   (seq_sel_i),
    .cont_i  (cont_mode_i),
    .data_o  (tx_data_o),
    .valid_o (tx_valid_o)
  );

  prbs_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (ctrl_we_i),
    .start_i    (ctrl_start_i),
    .sel_i      (seq_sel_i),
    .rx_data_i  (rx_data_i),
    .rx_valid_i (rx_valid_i),
    .cmp_vld_o  (cmp_vld),
    .mism_o     (mism)
  );

  prbs_stat #(.CNT_W(CNT_W), .PASS_RUN(PASS_RUN)) u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (ctrl_we_i),
    .cmp_vld_i (cmp_vld),
    .mism_i    (mism),
    .pass_o    (pass_o),
    .err_cnt_o (err_cnt_o)
  );

  AST_STOP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> (!pass_o && err_cnt_o == '0)); // R10
endmodule

// File: tb/test_prbs_bist.sv
module test_prbs_bist;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0, start = 1'b0, seq_sel = 1'b0, cont = 1'b0;
  logic tx_data, tx_valid, pass;
  logic [7:0] err_cnt;
  logic lb_flip = 1'b0, lb_en = 1'b1, use_ext = 1'b0, ext_bit = 1'b0, ext_vld = 1'b0;
  logic rx_data, rx_valid;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit ref9 [0:1022];
  bit ref15 [0:299];

  always #2 clk = ~clk;

  assign rx_data  = use_ext ? ext_bit : (tx_data ^ lb_flip);
  assign rx_valid = use_ext ? ext_vld : (tx_valid & lb_en);

  prbs_bist i_prbs_bist (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .ctrl_we_i    (we),
    .ctrl_start_i (start),
    .seq_sel_i    (seq_sel),
    .cont_mode_i  (cont),
    .tx_data_o    (tx_data),
    .tx_valid_o   (tx_valid),
    .rx_data_i    (rx_data),
    .rx_valid_i   (rx_valid),
    .pass_o       (pass),
    .err_cnt_o    (err_cnt)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit st, input bit sel);
    @(negedge clk);
    we = 1'b1; start = st; seq_sel = sel;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 200000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int vcount, k, nvalid;
    for (int i = 0; i < 9; i++) ref9[i] = 1'b1;
    for (int i = 0; i + 9 < 1023; i++) ref9[i+9] = ref9[i] ^ ref9[i+4];
    for (int i = 0; i < 15; i++) ref15[i] = 1'b1;
    for (int i = 0; i + 15 < 300; i++) ref15[i+15] = ref15[i] ^ ref15[i+1];

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 pass", pass, 0);
    chk("R1 err_cnt", err_cnt, 0);
    chk("R1 tx_valid", tx_valid, 0);
    rst_n = 1'b1;

    // short sequence, one shot, loopback
    cont = 1'b0;
    wr(1'b1, 1'b0);
    vcount = 0;
    for (int i = 0; i < 520; i++) begin
      if (tx_valid) vcount++;
      if (i < 511) chk("R2 tx bit", tx_data, ref9[i]);
      if (i == 136) chk("R7 pass before run", pass, 0);
      if (i == 137) chk("R7 pass after run", pass, 1);
      @(negedge clk);
    end
    chk("R4 short valid cycles", vcount, 511);
    chk("R4 short err_cnt", err_cnt, 0);
    chk("R4 pass held", pass, 1);

    // continuous, single error, saturation, stop
    cont = 1'b1;
    wr(1'b1, 1'b0);
    for (int i = 0; i < 1200; i++) begin
      if (i < 511) chk("R2 tx bit cont", tx_data, ref9[i]);
      else chk("R5 tx repeat", tx_data, ref9[i % 511]);
      if (i == 301) chk("R8 single error", err_cnt, 1);
      if (i == 301) chk("R8 pass dropped", pass, 0);
      lb_flip = (i == 300);
      @(negedge clk);
    end
    chk("R5 still valid", tx_valid, 1);
    chk("R8 pass sticky", pass, 0);
    chk("R8 count steady", err_cnt, 1);
    for (int i = 0; i < 300; i++) begin
      lb_flip = 1'b1;
      @(negedge clk);
    end
    lb_flip = 1'b0;
    chk("R9 saturated", err_cnt, 255);
    wr(1'b0, 1'b0);
    chk("R10 err cleared", err_cnt, 0);
    chk("R10 pass cleared", pass, 0);
    chk("R10 tx stopped", tx_valid, 0);
    use_ext = 1'b1;
    for (int i = 0; i < 20; i++) begin
      ext_vld = 1'b1; ext_bit = i[0];
      @(negedge clk);
    end
    ext_vld = 1'b0;
    chk("R10 no compare when stopped", err_cnt, 0);
    use_ext = 1'b0;

    // long sequence, one shot
    cont = 1'b0;
    wr(1'b1, 1'b1);
    vcount = 0;
    for (int i = 0; i < 32800; i++) begin
      if (tx_valid) vcount++;
      if (i < 300) chk("R3 tx bit", tx_data, ref15[i]);
      if (i == 142) chk("R7 long pass before", pass, 0);
      if (i == 143) chk("R7 long pass after", pass, 1);
      @(negedge clk);
    end
    chk("R4 long valid cycles", vcount, 32767);
    chk("R3 long err_cnt", err_cnt, 0);

    // offset stream with gaps
    use_ext = 1'b1;
    wr(1'b1, 1'b0);
    k = 100;
    nvalid = 0;
    for (int i = 0; i < 400; i++) begin
      if (i[0]) begin
        ext_vld = 1'b1; ext_bit = ref9[k]; k++;
      end else begin
        ext_vld = 1'b0; ext_bit = ~ref9[k];
      end
      @(negedge clk);
      if (i[0]) nvalid++;
      chk("R6 pass after offset sync", pass, (nvalid >= 137) ? 1 : 0);
    end
    chk("R11 gaps ignored", err_cnt, 0);
    ext_vld = 1'b0;

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule